// File: doc/BRIEF.md
# Halfword-select signed multiply-accumulate-long unit

This execution datapath takes two 32-bit source words. A select bit for each word picks its upper or lower 16 bits. The two chosen halves are multiplied as two's-complement numbers into a 32-bit product. The product is sign-extended and added to a 64-bit accumulator, which arrives as an upper word and a lower word. The new sum leaves the unit the same way, split into an upper word and a lower word. The 64-bit addition wraps silently. The surrounding core supplies a condition-pass bit and the four register indices of the operation. The unit flags any index combination that is not allowed and returns a write-enable to the register file.

The unit is a two-stage pipeline with a fixed latency. The first stage registers the product, the incoming accumulator and the index flag. The second stage registers the 64-bit result. Each stage carries a slot state:

- SLOT_IDLE means the slot holds nothing.
- SLOT_LIVE means the condition passed and the sum is written.
- SLOT_SKIP means the condition failed and the incoming accumulator passes through.

On every clock the first stage moves to SLOT_IDLE when start is low. With start high it moves to SLOT_LIVE when cond_pass is high and to SLOT_SKIP when cond_pass is low. The second stage copies the state of the first stage one cycle later. Reset forces both stages to SLOT_IDLE. A new start is accepted on every cycle.

Top module: `hmacl_unit`

## Requirements
- R1: The first operand is src_a[31:16] when sel_a is 1 and src_a[15:0] when sel_a is 0. The unused half has no effect on the result.
- R2: The second operand is chosen from src_b by sel_b in the same way, independently of sel_a.
- R3: Both operands are signed 16-bit values. 0x8000 times 0x8000 gives the product 0x40000000, and that product is positive.
- R4: The 32-bit product is sign-extended to 64 bits. A negative product added to a zero accumulator sets res_hi to 0xFFFFFFFF.
- R5: The accumulator is {acc_hi_in, acc_lo_in}. The result is split as res_hi = sum[63:32] and res_lo = sum[31:0]. A carry passes from the lower word into the upper word, and the sum wraps modulo 2^64 with no overflow indication.
- R6: When cond_pass is 0 for an issued operation, res_hi and res_lo equal the incoming acc_hi_in and acc_lo_in, and wr_en stays 0 while out_valid is 1.
- R7: bad_regs is 1 for a result when any of idx_lo, idx_hi, idx_a or idx_b equals 15, or when idx_hi equals idx_lo. Otherwise it is 0.
- R8: out_valid is 1 exactly two clock edges after a cycle with start high, whatever the data or cond_pass values.
- R9: Starts on consecutive cycles give results on consecutive cycles, in issue order.
- R10: A synchronous active-high reset clears out_valid, wr_en, bad_regs, res_hi and res_lo.
- R11: When out_valid is 0, wr_en and bad_regs are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue an operation this cycle |
| cond_pass | input | 1 | Condition passed; 0 turns the operation into a pass-through |
| sel_a | input | 1 | 1 selects the upper half of src_a |
| sel_b | input | 1 | 1 selects the upper half of src_b |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_hi_in | input | 32 | Accumulator bits 63:32 |
| acc_lo_in | input | 32 | Accumulator bits 31:0 |
| idx_lo | input | 4 | Register index of the lower accumulator word |
| idx_hi | input | 4 | Register index of the upper accumulator word |
| idx_a | input | 4 | Register index of src_a |
| idx_b | input | 4 | Register index of src_b |
| out_valid | output | 1 | A result is present this cycle |
| wr_en | output | 1 | Write the result back to the register file |
| bad_regs | output | 1 | The index combination is not allowed |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |

## Verification
The assertions assume that reset is held for at least one clock edge before the first start. They also assume that start is a clean known level and that the data, select and index inputs are stable around the edge that samples them. The bench keeps start low during reset and changes every input only on falling edges. It drives each operand pattern for exactly one sampling edge, so every issued operation matches the slot state that the assertions expect.

// File: rtl/hmacl_pkg.sv
package hmacl_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'b00,
        SLOT_LIVE = 2'b01,
        SLOT_SKIP = 2'b10
    } slot_e;

    localparam int unsigned IDX_COUNT = 4;

endpackage

// File: rtl/hmacl_reg_check.sv
module hmacl_reg_check #(
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx_lo,
    input  logic [IDX_W-1:0] idx_hi,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic             bad
);
    import hmacl_pkg::*;

    localparam logic [IDX_W-1:0] RESERVED_IDX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] idx_all [IDX_COUNT];
    logic [IDX_COUNT-1:0] hits_reserved;

    assign idx_all[0] = idx_lo;
    assign idx_all[1] = idx_hi;
    assign idx_all[2] = idx_a;
    assign idx_all[3] = idx_b;

    for (genvar g = 0; g < IDX_COUNT; g++) begin : g_reserved
        assign hits_reserved[g] = (idx_all[g] == RESERVED_IDX);
    end

    assign bad = (|hits_reserved) || (idx_hi == idx_lo);

endmodule

// File: rtl/hmacl_mul_stage.sv
module hmacl_mul_stage #(
    parameter int unsigned HALF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cond_pass,
    input  logic                    bad_in,
    input  logic                    sel_a,
    input  logic                    sel_b,
    input  logic [2*HALF_W-1:0]     src_a,
    input  logic [2*HALF_W-1:0]     src_b,
    input  logic [4*HALF_W-1:0]     acc_in,
    output hmacl_pkg::slot_e        slot_q,
    output logic [2*HALF_W-1:0]     prod_q,
    output logic [4*HALF_W-1:0]     acc_q,
    output logic                    bad_q
);
    import hmacl_pkg::*;

    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned PROD_W = 2 * HALF_W;
    localparam int unsigned ACC_W  = 2 * WORD_W;

    slot_e slot_d;
    logic signed [HALF_W-1:0] op_a;
    logic signed [HALF_W-1:0] op_b;
    logic signed [PROD_W-1:0] ext_a;
    logic signed [PROD_W-1:0] ext_b;
    logic signed [PROD_W-1:0] prod_d;

    assign op_a   = sel_a ? src_a[WORD_W-1:HALF_W] : src_a[HALF_W-1:0];
    assign op_b   = sel_b ? src_b[WORD_W-1:HALF_W] : src_b[HALF_W-1:0];
    assign ext_a  = {{HALF_W{op_a[HALF_W-1]}}, op_a};
    assign ext_b  = {{HALF_W{op_b[HALF_W-1]}}, op_b};
    assign prod_d = ext_a * ext_b;

    always_comb begin
        unique case ({start, cond_pass})
            2'b11:   slot_d = SLOT_LIVE;
            2'b10:   slot_d = SLOT_SKIP;
            default: slot_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_IDLE;
        else     slot_q <= slot_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            acc_q  <= '0;
            bad_q  <= 1'b0;
        end else if (start) begin
            prod_q <= prod_d;
            acc_q  <= acc_in;
            bad_q  <= bad_in;
        end
    end

    // R3
    prod_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op_a != '0 && op_b != '0)
            |=> (prod_q[PROD_W-1] == $past(op_a[HALF_W-1] ^ op_b[HALF_W-1])));

    // R3
    prod_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op_a == '0) |=> (prod_q == '0));

    localparam int unsigned UNUSED_ACC = ACC_W;

endmodule

// File: rtl/hmacl_acc_stage.sv
module hmacl_acc_stage #(
    parameter int unsigned HALF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  hmacl_pkg::slot_e        slot_in,
    input  logic [2*HALF_W-1:0]     prod_in,
    input  logic [4*HALF_W-1:0]     acc_in,
    input  logic                    bad_in,
    output logic                    out_valid,
    output logic                    wr_en,
    output logic                    bad_out,
    output logic [2*HALF_W-1:0]     res_hi,
    output logic [2*HALF_W-1:0]     res_lo
);
    import hmacl_pkg::*;

    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned PROD_W = 2 * HALF_W;
    localparam int unsigned ACC_W  = 2 * WORD_W;

    slot_e            slot_q;
    logic [ACC_W-1:0] sum_d;
    logic [ACC_W-1:0] res_q;
    logic             bad_q;

    assign sum_d = acc_in + {{(ACC_W-PROD_W){prod_in[PROD_W-1]}}, prod_in};

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_IDLE;
        else     slot_q <= slot_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            bad_q <= 1'b0;
        end else begin
            unique case (slot_in)
                SLOT_LIVE: res_q <= sum_d;
                SLOT_SKIP: res_q <= acc_in;
                default:   res_q <= res_q;
            endcase
            bad_q <= (slot_in != SLOT_IDLE) && bad_in;
        end
    end

    always_comb begin
        unique case (slot_q)
            SLOT_LIVE: begin out_valid = 1'b1; wr_en = 1'b1; end
            SLOT_SKIP: begin out_valid = 1'b1; wr_en = 1'b0; end
            default:   begin out_valid = 1'b0; wr_en = 1'b0; end
        endcase
    end

    assign bad_out = bad_q;
    assign res_hi  = res_q[ACC_W-1:WORD_W];
    assign res_lo  = res_q[WORD_W-1:0];

    // R6
    skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_in == SLOT_SKIP) |=> ({res_hi, res_lo} == $past(acc_in)));

    // R5
    zero_add_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_in == SLOT_LIVE && prod_in == '0) |=> ({res_hi, res_lo} == $past(acc_in)));

endmodule

// File: rtl/hmacl_unit.sv
module hmacl_unit #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cond_pass,
    input  logic                sel_a,
    input  logic                sel_b,
    input  logic [2*HALF_W-1:0] src_a,
    input  logic [2*HALF_W-1:0] src_b,
    input  logic [2*HALF_W-1:0] acc_hi_in,
    input  logic [2*HALF_W-1:0] acc_lo_in,
    input  logic [IDX_W-1:0]    idx_lo,
    input  logic [IDX_W-1:0]    idx_hi,
    input  logic [IDX_W-1:0]    idx_a,
    input  logic [IDX_W-1:0]    idx_b,
    output logic                out_valid,
    output logic                wr_en,
    output logic                bad_regs,
    output logic [2*HALF_W-1:0] res_hi,
    output logic [2*HALF_W-1:0] res_lo
);
    import hmacl_pkg::*;

    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned ACC_W  = 2 * WORD_W;
    localparam logic [IDX_W-1:0] RESERVED_IDX = {IDX_W{1'b1}};

    logic               bad_now;
    slot_e              mid_slot;
    logic [WORD_W-1:0]  mid_prod;
    logic [ACC_W-1:0]   mid_acc;
    logic               mid_bad;

    hmacl_reg_check #(.IDX_W(IDX_W)) u_check (
        .idx_lo (idx_lo),
        .idx_hi (idx_hi),
        .idx_a  (idx_a),
        .idx_b  (idx_b),
        .bad    (bad_now)
    );

    hmacl_mul_stage #(.HALF_W(HALF_W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cond_pass (cond_pass),
        .bad_in    (bad_now),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .src_a     (src_a),
        .src_b     (src_b),
        .acc_in    ({acc_hi_in, acc_lo_in}),
        .slot_q    (mid_slot),
        .prod_q    (mid_prod),
        .acc_q     (mid_acc),
        .bad_q     (mid_bad)
    );

    hmacl_acc_stage #(.HALF_W(HALF_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .slot_in   (mid_slot),
        .prod_in   (mid_prod),
        .acc_in    (mid_acc),
        .bad_in    (mid_bad),
        .out_valid (out_valid),
        .wr_en     (wr_en),
        .bad_out   (bad_regs),
        .res_hi    (res_hi),
        .res_lo    (res_lo)
    );

    // R8
    lat_two_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> ##2 out_valid);

    // R8
    idle_two_chk: assert property (@(posedge clk) disable iff (rst)
        !start |-> ##2 !out_valid);

    // R11
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    // R11
    bad_gate_chk: assert property (@(posedge clk) disable iff (rst)
        bad_regs |-> out_valid);

    // R7
    reserved_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (idx_a == RESERVED_IDX || idx_b == RESERVED_IDX)) |-> ##2 bad_regs);

    // R7
    same_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (start && idx_hi == idx_lo) |-> ##2 bad_regs);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !wr_en && !bad_regs && res_hi == '0 && res_lo == '0));

endmodule

// File: tb/hmacl_unit_test.sv
module hmacl_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, cond_pass, sel_a, sel_b;
    logic [31:0] src_a, src_b, acc_hi_in, acc_lo_in;
    logic [3:0]  idx_lo, idx_hi, idx_a, idx_b;
    logic        out_valid, wr_en, bad_regs;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hmacl_unit uut (
        .clk(clk), .rst(rst), .start(start), .cond_pass(cond_pass),
        .sel_a(sel_a), .sel_b(sel_b), .src_a(src_a), .src_b(src_b),
        .acc_hi_in(acc_hi_in), .acc_lo_in(acc_lo_in),
        .idx_lo(idx_lo), .idx_hi(idx_hi), .idx_a(idx_a), .idx_b(idx_b),
        .out_valid(out_valid), .wr_en(wr_en), .bad_regs(bad_regs),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic logic [63:0] model(input logic sa, input logic sb,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
        logic signed [15:0] x, y;
        logic signed [31:0] p;
        x = sa ? a[31:16] : a[15:0];
        y = sb ? b[31:16] : b[15:0];
        p = 32'(x) * 32'(y);
        return acc + {{32{p[31]}}, p};
    endfunction

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic cp, input logic sa, input logic sb,
                         input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                         input logic [3:0] ilo, input logic [3:0] ihi,
                         input logic [3:0] ia, input logic [3:0] ib);
        start = st; cond_pass = cp; sel_a = sa; sel_b = sb;
        src_a = a; src_b = b; {acc_hi_in, acc_lo_in} = acc;
        idx_lo = ilo; idx_hi = ihi; idx_a = ia; idx_b = ib;
    endtask

    // issue one operation with legal indices and wait until its result is out
    task automatic run_one(input logic cp, input logic sa, input logic sb,
                           input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
        drive(1'b1, cp, sa, sb, a, b, acc, 4'd0, 4'd1, 4'd2, 4'd3);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk1("R10 valid after reset", out_valid, 1'b0);
        chk1("R10 wr_en after reset", wr_en, 1'b0);
        chk1("R10 bad after reset", bad_regs, 1'b0);
        chk64("R10 result after reset", {res_hi, res_lo}, 64'h0);
    endtask

    task automatic t_select;
        logic [31:0] a = 32'h0003_FFFE;
        logic [31:0] b = 32'h0005_0007;
        logic [63:0] acc = 64'h0000_0010_0000_0100;
        for (int k = 0; k < 4; k++) begin
            logic sa = k[1];
            logic sb = k[0];
            run_one(1'b1, sa, sb, a, b, acc);
            chk64($sformatf("R1 R2 select a=%0d b=%0d", sa, sb), {res_hi, res_lo},
                  model(sa, sb, a, b, acc));
            chk1("R2 wr_en on live op", wr_en, 1'b1);
        end
        run_one(1'b1, 1'b0, 1'b0, 32'h0003_FFFE, 32'h0005_0007, 64'h0);
        chk64("R1 bottom-bottom -2*7", {res_hi, res_lo}, 64'hFFFF_FFFF_FFFF_FFF2);
        run_one(1'b1, 1'b0, 1'b0, 32'hABCD_FFFE, 32'h1234_0007, 64'h0);
        chk64("R1 unused halves ignored", {res_hi, res_lo}, 64'hFFFF_FFFF_FFFF_FFF2);
        run_one(1'b1, 1'b1, 1'b0, 32'h0003_FFFE, 32'h0005_0007, 64'h0);
        chk64("R2 top-bottom 3*7", {res_hi, res_lo}, 64'h0000_0000_0000_0015);
    endtask

    task automatic t_min_square;
        run_one(1'b1, 1'b1, 1'b0, 32'h8000_1111, 32'h2222_8000, 64'h0);
        chk64("R3 0x8000*0x8000", {res_hi, res_lo}, 64'h0000_0000_4000_0000);
    endtask

    task automatic t_neg_zero;
        run_one(1'b1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001, 64'h0);
        chk64("R4 negative product sign-extended", {res_hi, res_lo}, 64'hFFFF_FFFF_FFFF_FFFF);
        run_one(1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'h7FFF_0000, 64'h0);
        chk64("R4 -32768*32767", {res_hi, res_lo}, 64'hFFFF_FFFF_C000_8000);
    endtask

    task automatic t_wrap;
        run_one(1'b1, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF_FFFF_FFFF);
        chk64("R5 wrap from max positive", {res_hi, res_lo}, 64'h8000_0000_0000_0000);
        run_one(1'b1, 1'b0, 1'b0, 32'h1, 32'h1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk64("R5 wrap to zero", {res_hi, res_lo}, 64'h0);
        run_one(1'b1, 1'b0, 1'b0, 32'h1, 32'h1, 64'h0000_0000_FFFF_FFFF);
        chk64("R5 carry into upper word", {res_hi, res_lo}, 64'h0000_0001_0000_0000);
    endtask

    task automatic t_cond_fail;
        run_one(1'b0, 1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_0000, 64'h1111_2222_3333_4444);
        chk64("R6 pass-through on cond fail", {res_hi, res_lo}, 64'h1111_2222_3333_4444);
        chk1("R6 wr_en low on cond fail", wr_en, 1'b0);
        chk1("R6 R8 valid on cond fail", out_valid, 1'b1);
    endtask

    task automatic t_bad_idx;
        logic [3:0] cases [6][4];
        logic       expect_bad [6];
        cases[0] = '{4'd0, 4'd1, 4'd2, 4'd3};   expect_bad[0] = 1'b0;
        cases[1] = '{4'd15, 4'd1, 4'd2, 4'd3};  expect_bad[1] = 1'b1;
        cases[2] = '{4'd0, 4'd15, 4'd2, 4'd3};  expect_bad[2] = 1'b1;
        cases[3] = '{4'd0, 4'd1, 4'd15, 4'd3};  expect_bad[3] = 1'b1;
        cases[4] = '{4'd0, 4'd1, 4'd2, 4'd15};  expect_bad[4] = 1'b1;
        cases[5] = '{4'd6, 4'd6, 4'd2, 4'd3};   expect_bad[5] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h2, 32'h3, 64'h0,
                  cases[k][0], cases[k][1], cases[k][2], cases[k][3]);
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk1($sformatf("R7 index case %0d", k), bad_regs, expect_bad[k]);
        end
    endtask

    task automatic t_latency;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h5, 32'h5, 64'h0, 4'd0, 4'd1, 4'd2, 4'd3);
        @(negedge clk);
        start = 1'b0;
        chk1("R8 not valid after one edge", out_valid, 1'b0);
        @(negedge clk);
        chk1("R8 valid after two edges", out_valid, 1'b1);
        @(negedge clk);
        chk1("R8 valid drops after one cycle", out_valid, 1'b0);
    endtask

    task automatic t_back2back;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0003, 64'h100,
              4'd0, 4'd1, 4'd2, 4'd3);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFE_0000, 32'h0009_0000, 64'h200,
              4'd0, 4'd1, 4'd2, 4'd3);
        @(negedge clk);
        start = 1'b0;
        chk64("R9 first of pair", {res_hi, res_lo}, 64'h10C);
        chk1("R9 first valid", out_valid, 1'b1);
        @(negedge clk);
        chk64("R9 second of pair", {res_hi, res_lo}, 64'h1EE);
        chk1("R9 second valid", out_valid, 1'b1);
    endtask

    task automatic t_idle;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h1, 32'h1, 64'h0, 4'd15, 4'd15, 4'd2, 4'd3);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk1("R7 flagged op", bad_regs, 1'b1);
        @(negedge clk);
        chk1("R11 bad low when idle", bad_regs, 1'b0);
        chk1("R11 wr_en low when idle", wr_en, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 64'h0, 4'd0, 4'd1, 4'd2, 4'd3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select();
        t_min_square();
        t_neg_zero();
        t_wrap();
        t_cond_fail();
        t_bad_idx();
        t_latency();
        t_back2back();
        t_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule